// File: doc/BRIEF.md
# Isochronous Clock Source Selector

This block picks the bit clocks of a serial port and drives the port's two outgoing timing pins. The transmit and receive clock enables can each come from the local baud ticks or from either of two timing lines that the remote equipment supplies. Each outgoing pin can stay undriven or carry one of four sources: either local generator or either incoming timing line. The whole block runs on one system clock. The incoming timing lines are asynchronous. They are synchronized, and each of their rising edges becomes a single-cycle enable.

Input flow control works by stopping the clock. When flow control is enabled and the local receiver must pause, every driven outgoing pin is held low. The remote side clocks its data from that pin, so its transmission stops. Halting and resuming happen only while the selected source is low. As a result, no clipped high pulse ever reaches a pin. A 12-bit configuration word sets every selection. An all-zero word gives plain asynchronous operation.

Top module: `isoclk_select`

## Requirements
- R1: cfg_word[2:0] selects the transmit enable. Code 0 passes tx_baud_tick, code 1 uses edges of ext_txt, and code 2 uses edges of ext_rxt. With code 0, tx_clk_en equals tx_baud_tick one clock later.
- R2: cfg_word[5:3] selects the receive enable with the same codes. With code 0, rx_clk_en equals rx_baud_tick one clock later.
- R3: A rising level on a selected timing input gives exactly one single-cycle enable. It appears after the third rising clock edge that follows the change. A falling level or a steady level gives no enable.
- R4: Codes 3 to 7 in either input selector behave like code 0.
- R5: cfg_word[8:6] controls pin A (out_a_clk, out_a_oe). Code 0 gives oe low and a low line. Code 1 gives the receive generator square wave, which toggles on each rx_baud_tick and reaches the pin one clock after its own register. Code 2 gives the transmit generator square wave in the same way. Code 3 gives the ext_txt level and code 4 the ext_rxt level, each three clocks after the input changes.
- R6: cfg_word[11:9] controls pin B (out_b_clk, out_b_oe) with the same codes.
- R7: Output codes 5 to 7 behave like code 0 (oe low, line low).
- R8: While flow_en and stop_in are both high, a driven pin is held low. Halting and restarting take effect only while the selected source level is low, so each high interval on the pin is a complete source high interval.
- R9: When no pin is driven, flow_en and stop_in have no visible effect. The clock enables never depend on them.
- R10: While rst_n is low, all outputs are low and both generator square waves restart low.
- R11: An all-zero configuration gives plain asynchronous operation: both enables follow the local ticks and both pins are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 12 | Selector fields for tx, rx, pin A, pin B |
| tx_baud_tick | input | 1 | Local transmit baud tick (one cycle) |
| rx_baud_tick | input | 1 | Local receive baud tick (one cycle) |
| ext_txt | input | 1 | Incoming transmitter timing line, asynchronous |
| ext_rxt | input | 1 | Incoming receiver timing line, asynchronous |
| flow_en | input | 1 | Enables clock-stopping input flow control |
| stop_in | input | 1 | Local input must pause |
| tx_clk_en | output | 1 | Selected transmit clock enable |
| rx_clk_en | output | 1 | Selected receive clock enable |
| out_a_clk | output | 1 | Outgoing clock line A |
| out_a_oe | output | 1 | Drive enable for line A |
| out_b_clk | output | 1 | Outgoing clock line B |
| out_b_oe | output | 1 | Drive enable for line B |

## Verification
Every pair of input-selector codes, reserved codes included, is driven with random local ticks and random timing-line levels. This separates a tick-fed enable from an edge-fed enable and shows that a reserved code falls back to the ticks. Every pair of output-selector codes is then driven with random flow-control requests. A request that arrives while a source is high tells a correct low-phase gate apart from one that clips pulses. Directed runs with a timing line held high and then low check the edge-to-enable latency and that each edge gives only one pulse.

// File: rtl/isoclk_pkg.sv
`timescale 1ns/1ps
package isoclk_pkg;
  localparam int SEL_W   = 3;
  localparam int CFG_W   = 4 * SEL_W;
  localparam int N_IN    = 2;   // transmit, receive
  localparam int N_PIN   = 2;   // outgoing pins A, B
  localparam int N_SRC   = 4;   // rx gen, tx gen, ext txt, ext rxt

  typedef enum logic [1:0] {
    PICK_TICK = 2'd0,
    PICK_TXT  = 2'd1,
    PICK_RXT  = 2'd2
  } in_pick_e;

  typedef struct packed {
    logic       drive;
    logic [1:0] idx;
  } out_pick_t;

  function automatic in_pick_e decode_in(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return PICK_TXT;
      3'd2:    return PICK_RXT;
      default: return PICK_TICK;
    endcase
  endfunction

  function automatic out_pick_t decode_out(input logic [SEL_W-1:0] code);
    out_pick_t r;
    r.drive = (code >= 3'd1) && (code <= 3'd4);
    r.idx   = r.drive ? 2'(code - 3'd1) : 2'd0;
    return r;
  endfunction
endpackage

// File: rtl/isoclk_sync_edge.sv
`timescale 1ns/1ps
module isoclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q, sh_d;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = async_in;
    end else begin : g_many
      always_comb sh_d = {sh_q[LAST-1:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[LAST];
    end
  end

  assign lvl  = sh_q[LAST];
  assign rise = sh_q[LAST] & ~prev_q;
endmodule

// File: rtl/isoclk_out_pin.sv
`timescale 1ns/1ps
module isoclk_out_pin
  import isoclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             hold_req,
  output logic             line,
  output logic             oe
);
  out_pick_t pick;
  logic      lvl_sel;
  logic      run_q, run_d;
  logic      line_q, line_d;
  logic      oe_q, oe_d;

  always_comb begin
    pick    = decode_out(code);
    lvl_sel = pick.drive & src_lvl[pick.idx];
    // gate may only change while the chosen source is low
    run_d   = lvl_sel ? run_q : ~hold_req;
    line_d  = pick.drive & run_d & lvl_sel;
    oe_d    = pick.drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      line_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      line_q <= line_d;
      oe_q   <= oe_d;
    end
  end

  assign line = line_q;
  assign oe   = oe_q;
endmodule

// File: rtl/isoclk_select.sv
`timescale 1ns/1ps
module isoclk_select
  import isoclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             tx_baud_tick,
  input  logic             rx_baud_tick,
  input  logic             ext_txt,
  input  logic             ext_rxt,
  input  logic             flow_en,
  input  logic             stop_in,
  output logic             tx_clk_en,
  output logic             rx_clk_en,
  output logic             out_a_clk,
  output logic             out_a_oe,
  output logic             out_b_clk,
  output logic             out_b_oe
);
  localparam int PIN_BASE = N_IN * SEL_W;

  logic [1:0]       ext_async, ext_lvl, ext_rise;
  logic [N_IN-1:0]  ticks, en_d, en_q;
  logic             tx_ph_q, tx_ph_d, rx_ph_q, rx_ph_d;
  logic [N_SRC-1:0] src_lvl;
  logic             hold_req;
  logic [N_PIN-1:0] pin_line, pin_oe;

  assign ext_async = {ext_rxt, ext_txt};
  assign ticks     = {rx_baud_tick, tx_baud_tick};

  // timing-line synchronizers
  generate
    for (genvar e = 0; e < 2; e++) begin : g_sync
      isoclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_async[e]),
        .lvl(ext_lvl[e]), .rise(ext_rise[e])
      );
    end
  endgenerate

  // bit-clock enable selection
  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_in
      always_comb begin
        case (decode_in(cfg_word[g*SEL_W +: SEL_W]))
          PICK_TXT: en_d[g] = ext_rise[0];
          PICK_RXT: en_d[g] = ext_rise[1];
          default:  en_d[g] = ticks[g];
        endcase
      end
    end
  endgenerate

  // square waves from local generators
  always_comb begin
    tx_ph_d = tx_ph_q ^ tx_baud_tick;
    rx_ph_d = rx_ph_q ^ rx_baud_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      tx_ph_q <= 1'b0;
      rx_ph_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      tx_ph_q <= tx_ph_d;
      rx_ph_q <= rx_ph_d;
    end
  end

  assign src_lvl  = {ext_lvl[1], ext_lvl[0], tx_ph_q, rx_ph_q};
  assign hold_req = flow_en & stop_in;

  generate
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      isoclk_out_pin u_pin (
        .clk(clk), .rst_n(rst_n),
        .code(cfg_word[PIN_BASE + p*SEL_W +: SEL_W]),
        .src_lvl(src_lvl), .hold_req(hold_req),
        .line(pin_line[p]), .oe(pin_oe[p])
      );
    end
  endgenerate

  assign tx_clk_en = en_q[0];
  assign rx_clk_en = en_q[1];
  assign out_a_clk = pin_line[0];
  assign out_a_oe  = pin_oe[0];
  assign out_b_clk = pin_line[1];
  assign out_b_oe  = pin_oe[1];
endmodule

// File: rtl/isoclk_select_chk.sv
`timescale 1ns/1ps
module isoclk_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] cfg_word,
  input logic        tx_baud_tick,
  input logic        rx_baud_tick,
  input logic        ext_txt,
  input logic        ext_rxt,
  input logic        flow_en,
  input logic        stop_in,
  input logic        tx_clk_en,
  input logic        rx_clk_en,
  input logic        out_a_clk,
  input logic        out_a_oe,
  input logic        out_b_clk,
  input logic        out_b_oe
);
  logic req;
  assign req = flow_en & stop_in;

  // R1
  tx_tick_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(cfg_word[2:0]) == 3'd0)) |-> (tx_clk_en == $past(tx_baud_tick)));

  // R2
  rx_tick_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(cfg_word[5:3]) == 3'd0)) |-> (rx_clk_en == $past(rx_baud_tick)));

  // R3
  tx_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_word[2:0]) == 3'd1) && (cfg_word[2:0] == 3'd1) && tx_clk_en) |=> !tx_clk_en);

  // R7
  pin_a_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_a_oe |-> !out_a_clk);

  // R7
  pin_b_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_b_oe |-> !out_b_clk);

  // R5
  pin_a_oe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_a_oe == (($past(cfg_word[8:6]) >= 3'd1) && ($past(cfg_word[8:6]) <= 3'd4))));

  // R8
  pin_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) && req && !out_a_clk) |=> !out_a_clk);

  // R8
  pin_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) && req && !out_b_clk) |=> !out_b_clk);
endmodule

bind isoclk_select isoclk_select_chk u_chk (.*);

// File: tb/isoclk_select_bench.sv
`timescale 1ns/1ps
module isoclk_select_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_word = '0;
  logic        tx_baud_tick = 1'b0, rx_baud_tick = 1'b0;
  logic        ext_txt = 1'b0, ext_rxt = 1'b0;
  logic        flow_en = 1'b0, stop_in = 1'b0;
  logic        tx_clk_en, rx_clk_en, out_a_clk, out_a_oe, out_b_clk, out_b_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isoclk_select u_isoclk_select (.*);

  // reference model written from the requirements
  logic t1, t2, t3, r1, r2, r3;
  logic m_txph, m_rxph, m_txen, m_rxen;
  logic [1:0] m_run, m_line, m_oe;

  function automatic logic pick_en(input logic [2:0] c, input logic tick,
                                   input logic et, input logic er);
    if (c == 3'd1) return et;
    if (c == 3'd2) return er;
    return tick;
  endfunction

  function automatic logic pick_lvl(input logic [2:0] c, input logic rg,
                                    input logic tg, input logic lt, input logic lr);
    case (c)
      3'd1: return rg;
      3'd2: return tg;
      3'd3: return lt;
      3'd4: return lr;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {t1, t2, t3, r1, r2, r3} <= '0;
      {m_txph, m_rxph, m_txen, m_rxen} <= '0;
      m_run <= 2'b11; m_line <= '0; m_oe <= '0;
    end else begin
      t1 <= ext_txt; t2 <= t1; t3 <= t2;
      r1 <= ext_rxt; r2 <= r1; r3 <= r2;
      m_txph <= m_txph ^ tx_baud_tick;
      m_rxph <= m_rxph ^ rx_baud_tick;
      m_txen <= pick_en(cfg_word[2:0], tx_baud_tick, t2 & ~t3, r2 & ~r3);
      m_rxen <= pick_en(cfg_word[5:3], rx_baud_tick, t2 & ~t3, r2 & ~r3);
      for (int p = 0; p < 2; p++) begin
        logic [2:0] c;
        logic s, drv, rn;
        c   = cfg_word[6 + 3*p +: 3];
        s   = pick_lvl(c, m_rxph, m_txph, t2, r2);
        drv = (c >= 3'd1) && (c <= 3'd4);
        rn  = s ? m_run[p] : ~(flow_en & stop_in);
        m_run[p]  <= rn;
        m_line[p] <= drv & rn & s;
        m_oe[p]   <= drv;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic string in_tag(input logic [2:0] c, input string base);
    if (cfg_word == 12'd0) return "R11";
    if (c == 3'd0) return base;
    if (c <= 3'd2) return "R3";
    return "R4";
  endfunction

  function automatic string pin_tag(input logic [2:0] c, input string base);
    if (cfg_word == 12'd0) return "R11";
    if (c > 3'd4) return "R7";
    if (c == 3'd0) return (flow_en & stop_in) ? "R9" : base;
    if (flow_en & stop_in) return "R8";
    return base;
  endfunction

  task automatic check_all();
    chk(in_tag(cfg_word[2:0], "R1"), "tx_clk_en", tx_clk_en, m_txen);
    chk(in_tag(cfg_word[5:3], "R2"), "rx_clk_en", rx_clk_en, m_rxen);
    chk(pin_tag(cfg_word[8:6], "R5"), "out_a_clk", out_a_clk, m_line[0]);
    chk(pin_tag(cfg_word[8:6], "R5"), "out_a_oe", out_a_oe, m_oe[0]);
    chk(pin_tag(cfg_word[11:9], "R6"), "out_b_clk", out_b_clk, m_line[1]);
    chk(pin_tag(cfg_word[11:9], "R6"), "out_b_oe", out_b_oe, m_oe[1]);
  endtask

  task automatic rand_step(input int stop_rate);
    @(negedge clk);
    tx_baud_tick = ($urandom_range(0, 2) == 0);
    rx_baud_tick = ($urandom_range(0, 2) == 0);
    if ($urandom_range(0, 3) == 0) ext_txt = ~ext_txt;
    if ($urandom_range(0, 3) == 0) ext_rxt = ~ext_rxt;
    if ($urandom_range(0, stop_rate) == 0) stop_in = ~stop_in;
    if ($urandom_range(0, 15) == 0) flow_en = ~flow_en;
    @(posedge clk); #1;
    check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", "tx_clk_en", tx_clk_en, 1'b0);
    chk("R10", "rx_clk_en", rx_clk_en, 1'b0);
    chk("R10", "out_a", out_a_clk | out_a_oe, 1'b0);
    chk("R10", "out_b", out_b_clk | out_b_oe, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R11 plain asynchronous operation
    cfg_word = 12'd0;
    for (int i = 0; i < 40; i++) rand_step(3);

    // R1 R2 R3 R4 input selector sweep
    for (int ts = 0; ts < 8; ts++)
      for (int rs = 0; rs < 8; rs++) begin
        @(negedge clk) cfg_word = {6'd0, 3'(rs), 3'(ts)};
        for (int i = 0; i < 30; i++) rand_step(3);
      end

    // R5 R6 R7 R8 R9 output selector sweep with flow control
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        @(negedge clk) cfg_word = {3'(b), 3'(a), 6'd0};
        flow_en = 1'b1;
        for (int i = 0; i < 48; i++) rand_step(6);
      end

    // R9 pins off, flow stop held: nothing appears on the pins
    @(negedge clk);
    cfg_word = 12'd0; flow_en = 1'b1; stop_in = 1'b1;
    for (int i = 0; i < 24; i++) begin
      rand_step(1000);
      chk("R9", "pin A idle", out_a_clk | out_a_oe, 1'b0);
      chk("R9", "pin B idle", out_b_clk | out_b_oe, 1'b0);
    end

    // R3 directed edge latency, single pulse, no pulse on fall
    @(negedge clk);
    cfg_word = 12'h001; tx_baud_tick = 1'b0; rx_baud_tick = 1'b0;
    ext_txt = 1'b0; flow_en = 1'b0; stop_in = 1'b0;
    repeat (6) @(negedge clk);
    ext_txt = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk); #1;
      chk("R3", "rise pulse", tx_clk_en, (i == 3));
    end
    @(negedge clk) ext_txt = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk); #1;
      chk("R3", "no pulse on fall", tx_clk_en, 1'b0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule